// File: doc/BRIEF.md
# Flash Program/Erase Guard

This block sits between the register bus and the sequencer of an embedded flash array. Software writes a control register that selects program, erase, program-verify or erase-verify operation. A separate register selects which array blocks are open for modification. The guard turns these register contents into mode outputs for the sequencer. While a program or erase operation is active, it also drives a mask that holds off the non-maskable interrupt.

While program or erase is active, the guard watches for trouble. There are two external fault inputs: a runaway indication and an algorithm-violation indication. The guard also detects some illegal register settings of its own. Any such fault sets a sticky error flag. The program or erase output then drops, and no new program or erase can start. The register contents are kept, and the verify modes stay usable.

Only three events clear the error flag: the reset pin, a watchdog reset, or hardware standby. Entering software standby while the flag is set clears the control and block-enable registers, but the flag itself stays set.

Top module: `flash_guard`

## Requirements
- R1: On a clock edge where `rst_n` is low, `wdog_rst_n` is low, or `hw_stby` is high, the control register, the block-enable register, the error flag and `bus_rdata` all become 0.
- R2: The register map is as follows. Address 0 is control, with bit 0 = program, bit 1 = erase, bit 2 = program-verify and bit 3 = erase-verify. Address 1 is block-enable. Address 2 is status, with the error flag in bit 0. Address 3 reads 0. A read request (`bus_sel` high, `bus_wr` low) returns the pre-edge register value on `bus_rdata` after one clock edge. Unused bits read 0, and `bus_rdata` is 0 after an edge with no read request.
- R3: `prog_mode_o` is high exactly when the program bit is 1, the erase bit is 0, at least one block is enabled and the error flag is 0. `erase_mode_o` follows the same rule with the two bits swapped. The two outputs are never high together.
- R4: `nmi_mask_o` is high whenever the program bit or the erase bit is 1, whatever the error flag.
- R5: On an edge where the program or erase bit is 1 and `runaway_i` or `algo_fault_i` is high, the error flag becomes 1. Fault inputs seen while both bits are 0 are ignored.
- R6: The guard flags its own algorithm violations. If program and erase are both 1, or either is 1 while no block is enabled, the error flag becomes 1 at the next edge, and no mode output is asserted.
- R7: The error flag is sticky. Writes to the status address have no effect on it. When an error occurs, the control and block-enable registers keep their contents, and both remain writable while the flag is set.
- R8: While the error flag is 1, writing the program or erase bit asserts no mode output. `pverify_o` and `everify_o` still follow the program-verify and erase-verify bits.
- R9: An edge with `sw_stby` high while the error flag is 1 clears the control and block-enable registers and leaves the flag at 1. This takes precedence over a bus write in the same cycle. With the flag at 0, `sw_stby` has no effect.
- R10: A clearing event (R1) takes precedence over a fault detected on the same edge, so the error flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Reset pin, active low, synchronous |
| wdog_rst_n | input | 1 | Watchdog reset, active low, synchronous |
| hw_stby | input | 1 | Hardware standby entry, clears everything |
| sw_stby | input | 1 | Software standby entry |
| runaway_i | input | 1 | Runaway fault indication |
| algo_fault_i | input | 1 | External algorithm-violation indication |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| prog_mode_o | output | 1 | Program mode to sequencer |
| erase_mode_o | output | 1 | Erase mode to sequencer |
| pverify_o | output | 1 | Program-verify mode |
| everify_o | output | 1 | Erase-verify mode |
| nmi_mask_o | output | 1 | Masks the non-maskable interrupt |

## Verification
Two pairs of functions can fall on the same edge. The first is software standby and a bus write to the control register. The second is a fault on an active operation and a clearing event such as hardware standby. The bench drives each pair in a single cycle, once the error flag has reached the required state. It then reads the registers back over the bus. The expected outcome is that standby wins over the write and the clear wins over the fault. A behavioural model that runs on every clock gives the expected outputs in all the other cycles.

// File: rtl/flash_guard_pkg.sv
// Shared types for the flash program/erase guard.
// Assumes: control field positions are fixed because the sequencer decodes them.
package flash_guard_pkg;

    // Control register layout, bit 0 = program.
    typedef struct packed {
        logic ev;
        logic pv;
        logic er;
        logic pg;
    } fg_ctrl_t;

    localparam int CTRL_W = $bits(fg_ctrl_t);

    typedef enum logic [1:0] {
        FG_A_CTRL = 2'd0,
        FG_A_BLK  = 2'd1,
        FG_A_STAT = 2'd2,
        FG_A_NONE = 2'd3
    } fg_addr_e;

endpackage

// File: rtl/fg_regs.sv
// Control and block-enable registers.
// Assumes: clr is a combined synchronous clear; sw_clr clears both registers
// and takes precedence over same-cycle writes.
module fg_regs
    import flash_guard_pkg::*;
#(
    parameter int BLK_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              sw_clr,
    input  logic              wr_ctrl,
    input  logic              wr_blk,
    input  logic [DATA_W-1:0] wdata,
    output fg_ctrl_t          ctrl,
    output logic [BLK_W-1:0]  blk
);

    // Control register: clear, standby wipe, or bus write.
    always_ff @(posedge clk) begin
        if (clr || sw_clr)
            ctrl <= '0;
        else if (wr_ctrl)
            ctrl <= fg_ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Block-enable register: same precedence as control.
    always_ff @(posedge clk) begin
        if (clr || sw_clr)
            blk <= '0;
        else if (wr_blk)
            blk <= wdata[BLK_W-1:0];
    end

endmodule

// File: rtl/fg_errlatch.sv
// Sticky error flag.
// Assumes: faults are qualified by the active state here; only clr releases it.
module fg_errlatch (
    input  logic clk,
    input  logic clr,
    input  logic active,
    input  logic fault,
    output logic err
);

    // Set on a qualified fault, hold until a clearing event.
    always_ff @(posedge clk) begin
        if (clr)
            err <= 1'b0;
        else if (active && fault)
            err <= 1'b1;
    end

endmodule

// File: rtl/fg_modes.sv
// Mode output decode and internal violation detection.
// Assumes: pure combinational; err comes from the sticky latch.
module fg_modes
    import flash_guard_pkg::*;
#(
    parameter int BLK_W = 8
) (
    input  fg_ctrl_t         ctrl,
    input  logic [BLK_W-1:0] blk,
    input  logic             err,
    output logic             active,
    output logic             violation,
    output logic             prog_mode,
    output logic             erase_mode,
    output logic             pverify,
    output logic             everify
);

    logic any_blk;

    // Decode modes; program and erase need exclusivity, a block and no error.
    always_comb begin
        any_blk    = |blk;
        active     = ctrl.pg | ctrl.er;
        violation  = (ctrl.pg & ctrl.er) | (active & ~any_blk);
        prog_mode  = ctrl.pg & ~ctrl.er & any_blk & ~err;
        erase_mode = ctrl.er & ~ctrl.pg & any_blk & ~err;
        pverify    = ctrl.pv;
        everify    = ctrl.ev;
    end

endmodule

// File: rtl/flash_guard_chk.sv
// Assertion checker for flash_guard, attached by bind.
// Assumes: err is the top's internal error flag.
module flash_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic wdog_rst_n,
    input logic hw_stby,
    input logic runaway_i,
    input logic algo_fault_i,
    input logic err,
    input logic prog_mode_o,
    input logic erase_mode_o,
    input logic nmi_mask_o
);

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdog_rst_n || hw_stby) |=> (!err && !nmi_mask_o));

    assert_mode_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_mode_o && erase_mode_o));

    assert_nmi_cover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode_o || erase_mode_o) |-> nmi_mask_o);

    assert_fault_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_mask_o && (runaway_i || algo_fault_i) && wdog_rst_n && !hw_stby) |=> err);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && wdog_rst_n && !hw_stby) |=> err);

    assert_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!prog_mode_o && !erase_mode_o));

endmodule

bind flash_guard flash_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdog_rst_n   (wdog_rst_n),
    .hw_stby      (hw_stby),
    .runaway_i    (runaway_i),
    .algo_fault_i (algo_fault_i),
    .err          (err_q),
    .prog_mode_o  (prog_mode_o),
    .erase_mode_o (erase_mode_o),
    .nmi_mask_o   (nmi_mask_o)
);

// File: rtl/flash_guard.sv
// Flash program/erase guard top: register bus, fault latch, mode outputs.
// Assumes: all resets synchronous; BLK_W <= DATA_W and DATA_W >= CTRL_W.
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int BLK_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdog_rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              runaway_i,
    input  logic              algo_fault_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              prog_mode_o,
    output logic              erase_mode_o,
    output logic              pverify_o,
    output logic              everify_o,
    output logic              nmi_mask_o
);

    localparam int CTRL_PAD = DATA_W - CTRL_W;
    localparam int BLK_PAD  = DATA_W - BLK_W;

    logic             clr_all;
    logic             sw_wipe;
    logic             wr_ctrl;
    logic             wr_blk;
    logic             rd_req;
    logic             active;
    logic             violation;
    logic             fault_any;
    logic             err_q;
    fg_ctrl_t         ctrl_q;
    logic [BLK_W-1:0] blk_q;
    logic [DATA_W-1:0] rd_mux;

    // Event and access decode.
    always_comb begin
        clr_all   = ~rst_n | ~wdog_rst_n | hw_stby;
        sw_wipe   = sw_stby & err_q;
        wr_ctrl   = bus_sel & bus_wr & (fg_addr_e'(bus_addr) == FG_A_CTRL);
        wr_blk    = bus_sel & bus_wr & (fg_addr_e'(bus_addr) == FG_A_BLK);
        rd_req    = bus_sel & ~bus_wr;
        fault_any = runaway_i | algo_fault_i | violation;
    end

    fg_regs #(.BLK_W(BLK_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .clr     (clr_all),
        .sw_clr  (sw_wipe),
        .wr_ctrl (wr_ctrl),
        .wr_blk  (wr_blk),
        .wdata   (bus_wdata),
        .ctrl    (ctrl_q),
        .blk     (blk_q)
    );

    fg_modes #(.BLK_W(BLK_W)) u_modes (
        .ctrl       (ctrl_q),
        .blk        (blk_q),
        .err        (err_q),
        .active     (active),
        .violation  (violation),
        .prog_mode  (prog_mode_o),
        .erase_mode (erase_mode_o),
        .pverify    (pverify_o),
        .everify    (everify_o)
    );

    fg_errlatch u_err (
        .clk    (clk),
        .clr    (clr_all),
        .active (active),
        .fault  (fault_any),
        .err    (err_q)
    );

    // Interrupt mask follows the raw program/erase bits.
    always_comb nmi_mask_o = active;

    // Read mux, zero-extended fields.
    always_comb begin
        unique case (fg_addr_e'(bus_addr))
            FG_A_CTRL: rd_mux = {{CTRL_PAD{1'b0}}, ctrl_q};
            FG_A_BLK:  rd_mux = {{BLK_PAD{1'b0}}, blk_q};
            FG_A_STAT: rd_mux = {{(DATA_W-1){1'b0}}, err_q};
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data, one edge of latency.
    always_ff @(posedge clk) begin
        if (clr_all || !rd_req)
            bus_rdata <= '0;
        else
            bus_rdata <= rd_mux;
    end

endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wdog_rst_n = 1'b1;
    logic          hw_stby = 1'b0;
    logic          sw_stby = 1'b0;
    logic          runaway_i = 1'b0;
    logic          algo_fault_i = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          prog_mode_o, erase_mode_o, pverify_o, everify_o, nmi_mask_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Behavioural model state.
    int m_ctrl = 0;
    int m_blk = 0;
    int m_err = 0;
    int m_rd = 0;

    always #2 clk = ~clk;

    flash_guard u0 (
        .clk(clk), .rst_n(rst_n), .wdog_rst_n(wdog_rst_n), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .runaway_i(runaway_i), .algo_fault_i(algo_fault_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prog_mode_o(prog_mode_o), .erase_mode_o(erase_mode_o),
        .pverify_o(pverify_o), .everify_o(everify_o), .nmi_mask_o(nmi_mask_o)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model next state from the inputs at each edge.
    always @(posedge clk) begin
        int pg, er, act, viol, nx_ctrl, nx_blk, nx_err, nx_rd;
        pg = m_ctrl & 1;
        er = (m_ctrl >> 1) & 1;
        act = pg | er;
        viol = (pg & er) | (act & (m_blk == 0 ? 1 : 0));
        nx_ctrl = m_ctrl; nx_blk = m_blk; nx_err = m_err; nx_rd = 0;
        if (bus_sel && !bus_wr)
            case (bus_addr)
                2'd0: nx_rd = m_ctrl;
                2'd1: nx_rd = m_blk;
                2'd2: nx_rd = m_err;
                default: nx_rd = 0;
            endcase
        if (act != 0 && (runaway_i || algo_fault_i || viol != 0)) nx_err = 1;
        if (sw_stby && m_err != 0) begin
            nx_ctrl = 0; nx_blk = 0;
        end else if (bus_sel && bus_wr) begin
            if (bus_addr == 2'd0) nx_ctrl = int'(bus_wdata) & 15;
            if (bus_addr == 2'd1) nx_blk = int'(bus_wdata);
        end
        if (!rst_n || !wdog_rst_n || hw_stby) begin
            nx_ctrl = 0; nx_blk = 0; nx_err = 0; nx_rd = 0;
        end
        m_ctrl = nx_ctrl; m_blk = nx_blk; m_err = nx_err; m_rd = nx_rd;
    end

    // Compare all outputs against the model, 1 ns after each edge.
    task automatic cyc();
        int pg, er, anyb;
        @(posedge clk);
        #1;
        pg = m_ctrl & 1; er = (m_ctrl >> 1) & 1; anyb = (m_blk != 0) ? 1 : 0;
        chk(int'(prog_mode_o),  (pg & ~er & anyb & ~m_err) & 1, "R3 prog");
        chk(int'(erase_mode_o), (er & ~pg & anyb & ~m_err) & 1, "R3 erase");
        chk(int'(nmi_mask_o),   pg | er, "R4 nmi");
        chk(int'(pverify_o),    (m_ctrl >> 2) & 1, "R8 pverify");
        chk(int'(everify_o),    (m_ctrl >> 3) & 1, "R8 everify");
        chk(int'(bus_rdata),    m_rd, "R2 rdata");
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        cyc();
        chk(int'(bus_rdata), exp, tag);
        bus_sel = 1'b0;
    endtask

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        // R1: reset state.
        rd(2'd0, 0, "R1 ctrl after reset");
        rd(2'd2, 0, "R1 status after reset");
        // R3/R2: program mode with a block enabled.
        wr(2'd1, 8'h05);
        wr(2'd0, 8'h01);
        cyc();
        chk(int'(prog_mode_o), 1, "R3 program asserted");
        rd(2'd0, 1, "R2 ctrl readback");
        rd(2'd3, 0, "R2 unused address");
        // R5: fault while idle ignored.
        wr(2'd0, 8'h00);
        runaway_i = 1'b1; cyc(); runaway_i = 1'b0;
        rd(2'd2, 0, "R5 idle fault ignored");
        // R5: fault during erase.
        wr(2'd0, 8'h02);
        cyc();
        chk(int'(erase_mode_o), 1, "R3 erase asserted");
        runaway_i = 1'b1; cyc(); runaway_i = 1'b0;
        chk(int'(erase_mode_o), 0, "R5 erase dropped");
        rd(2'd2, 1, "R5 flag set");
        rd(2'd0, 2, "R7 ctrl kept");
        rd(2'd1, 5, "R7 blk kept");
        // R7: status write ignored; registers writable.
        wr(2'd2, 8'h00);
        rd(2'd2, 1, "R7 status write ignored");
        wr(2'd1, 8'h0c);
        rd(2'd1, 12, "R7 blk writable");
        // R8: program locked, verify allowed.
        wr(2'd0, 8'h01);
        cyc();
        chk(int'(prog_mode_o), 0, "R8 program locked");
        wr(2'd0, 8'h04);
        cyc();
        chk(int'(pverify_o), 1, "R8 pverify allowed");
        wr(2'd0, 8'h08);
        cyc();
        chk(int'(everify_o), 1, "R8 everify allowed");
        // R1: watchdog reset clears.
        wdog_rst_n = 1'b0; cyc(); wdog_rst_n = 1'b1;
        rd(2'd2, 0, "R1 watchdog clears flag");
        // R6: both bits set.
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h03);
        cyc();
        rd(2'd2, 1, "R6 both bits violation");
        rst_n = 1'b0; cyc(); rst_n = 1'b1;
        rd(2'd2, 0, "R1 reset pin clears flag");
        // R6: program with no block enabled.
        wr(2'd0, 8'h01);
        cyc();
        chk(int'(prog_mode_o), 0, "R6 no block no program");
        rd(2'd2, 1, "R6 no block violation");
        hw_stby = 1'b1; cyc(); hw_stby = 1'b0;
        rd(2'd2, 0, "R1 hw standby clears flag");
        // R9: software standby without error.
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h04);
        sw_stby = 1'b1; cyc(); sw_stby = 1'b0;
        rd(2'd0, 4, "R9 no-error standby ignored");
        rd(2'd1, 3, "R9 no-error standby blk");
        // R9: software standby with error, colliding with a write.
        wr(2'd0, 8'h02);
        algo_fault_i = 1'b1; cyc(); algo_fault_i = 1'b0;
        rd(2'd2, 1, "R5 algo fault sets flag");
        sw_stby = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h08;
        cyc();
        sw_stby = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd(2'd0, 0, "R9 standby beats write");
        rd(2'd1, 0, "R9 standby clears blk");
        rd(2'd2, 1, "R9 flag survives standby");
        // R10: clear beats fault on the same edge.
        hw_stby = 1'b1; cyc(); hw_stby = 1'b0;
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h01);
        runaway_i = 1'b1; hw_stby = 1'b1; cyc(); runaway_i = 1'b0; hw_stby = 1'b0;
        rd(2'd2, 0, "R10 clear wins over fault");
        rd(2'd0, 0, "R10 ctrl cleared");
        cyc(); cyc();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule